// File: doc/BRIEF.md
# I2C Bus Condition Status Monitor

This block listens passively to the two lines of an I2C bus and keeps three sticky status flags: one for a start condition, one for a stop condition and one for an acknowledge seen on the ninth clock of a byte. It also gives a one-cycle pulse each time one of these events is recognised. The bus lines are asynchronous to the system clock, so both pass through a configurable chain of synchronizing flops before edges and conditions are decoded.

Each flag is cleared by bus events rather than by reading it. The start flag marks the address phase: it drops on the first clock of the byte that follows the address byte. The acknowledge flag drops on the first clock of the next byte. The stop flag shows that the bus has been released. It is not cleared by the next start alone. It drops only on the first clock of the address byte that follows that start. A software release strobe ends the monitor's part in the current transfer by clearing the start and acknowledge flags, and leaves the stop flag alone. Pulling the enable input low clears everything and silences the monitor.

Two state machines do the work. The byte tracker has the states TRK_IDLE (no start seen), TRK_ADDR (address byte in progress) and TRK_DATA (later bytes). A start moves it from any state to TRK_ADDR with the count at zero. The first clock after the address acknowledge moves it from TRK_ADDR to TRK_DATA. A stop, or enable low, returns it to TRK_IDLE. The stop flag machine has the states STP_CLEAR, STP_SET and STP_ARMED. A stop moves it from any state to STP_SET. A start moves it from STP_SET to STP_ARMED. The first address clock moves it from STP_ARMED to STP_CLEAR. Enable low sends it to STP_CLEAR.

Top module: `i2c_cond_monitor`

## Requirements
- R1: A falling SDA while SCL is high (after synchronization) sets the start flag and gives one start pulse.
- R2: A rising SDA while SCL is high sets the stop flag, gives one stop pulse, and clears the start and acknowledge flags.
- R3: SCL rising edges are counted from zero at each start. On the ninth rising edge of a byte, an SDA level of 0 sets the acknowledge flag and gives one acknowledge pulse. An SDA level of 1 leaves the flag clear. After the ninth edge the next edge counts as 1.
- R4: The acknowledge flag clears on the rising SCL edge of the first clock of the next byte.
- R5: The start flag stays set through all nine clocks of the address byte and clears on the rising edge of the first clock of the following byte.
- R6: A set stop flag survives a new start condition. It clears on the first SCL rising edge after that start.
- R7: A release strobe clears the start and acknowledge flags, leaves the stop flag unchanged, and wins over a start or acknowledge set in the same cycle.
- R8: While enable is 0, all three flags are 0 and no pulses are given. After enable returns to 1, the flags stay 0 until a new bus event.
- R9: A start detected while the start flag is set (repeated start) restarts the byte count, so the start flag then lasts nine further clocks.
- R10: After reset all three flags and all three pulses are 0.
- R11: SCL clocks seen before any start condition change none of the flags.
- R12: Each event pulse lasts one cycle per bus condition, and start and stop pulses never occur together.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| scl_in | input | 1 | Raw SCL line level |
| sda_in | input | 1 | Raw SDA line level |
| enable | input | 1 | Monitor enable; 0 clears and holds all flags |
| release_pulse | input | 1 | One-cycle strobe that leaves the current transfer |
| start_flag | output | 1 | Sticky start-condition flag (address phase) |
| stop_flag | output | 1 | Sticky stop-condition flag (bus released) |
| ack_flag | output | 1 | Sticky acknowledge-detected flag |
| start_evt | output | 1 | One-cycle pulse on a start condition |
| stop_evt | output | 1 | One-cycle pulse on a stop condition |
| ack_evt | output | 1 | One-cycle pulse on a low ninth-clock SDA |

## Verification
The bench sweeps whole transfers over every combination of zero to three data bytes, both acknowledge levels on every byte, and several address and data bit patterns. Varying the byte count separates correct wrap of the ninth-clock count from a counter that drifts. Varying the acknowledge level separates sampling on the ninth edge from sampling on the eighth or tenth, since the address and data bits around it differ. Running transfers back to back, with and without a stop before each one, separates the armed stop-flag clear from a clear on the start itself. Separate sequences try release strobes, enable drops, a repeated start in the middle of a data byte, and clocks before any start.

// File: rtl/i2cmon_pkg.sv
package i2cmon_pkg;

    typedef enum logic [1:0] {
        TRK_IDLE,
        TRK_ADDR,
        TRK_DATA
    } trk_state_t;

    typedef enum logic [1:0] {
        STP_CLEAR,
        STP_SET,
        STP_ARMED
    } stp_state_t;

    typedef struct packed {
        logic start;
        logic stop;
        logic scl_rise;
    } bus_evt_t;

    typedef struct packed {
        logic addr_first;
        logic addr_done;
        logic byte_first;
        logic ack_low;
    } trk_strobe_t;

endpackage

// File: rtl/i2cmon_sync.sv
module i2cmon_sync #(
    parameter int STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic d,
    output logic q
);
    logic [STAGES-1:0] chain;

    genvar i;
    generate
        for (i = 0; i < STAGES; i++) begin : g_stage
            if (i == 0) begin : g_first
                always_ff @(posedge clk or negedge rst_n) begin
                    if (!rst_n) chain[0] <= 1'b1;
                    else        chain[0] <= d;
                end
            end else begin : g_next
                always_ff @(posedge clk or negedge rst_n) begin
                    if (!rst_n) chain[i] <= 1'b1;
                    else        chain[i] <= chain[i-1];
                end
            end
        end
    endgenerate

    assign q = chain[STAGES-1];
endmodule

// File: rtl/i2cmon_cond_detect.sv
module i2cmon_cond_detect
    import i2cmon_pkg::*;
(
    input  logic     clk,
    input  logic     rst_n,
    input  logic     scl_s,
    input  logic     sda_s,
    output bus_evt_t evt,
    output logic     sda_level
);
    logic scl_q;
    logic sda_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            scl_q <= 1'b1;
            sda_q <= 1'b1;
        end else begin
            scl_q <= scl_s;
            sda_q <= sda_s;
        end
    end

    always_comb begin
        evt.start    = scl_s & scl_q & sda_q & ~sda_s;
        evt.stop     = scl_s & scl_q & ~sda_q & sda_s;
        evt.scl_rise = scl_s & ~scl_q;
    end

    assign sda_level = sda_s;

    a_r12_cond_exclusive: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0({evt.start, evt.stop, evt.scl_rise}));
endmodule

// File: rtl/i2cmon_bit_track.sv
module i2cmon_bit_track
    import i2cmon_pkg::*;
#(
    parameter int BITS_PER_BYTE = 8
) (
    input  logic        clk,
    input  logic        rst_n,
    input  logic        enable,
    input  bus_evt_t    evt,
    input  logic        sda_level,
    output trk_strobe_t stb
);
    localparam int ACK_CLK_I = BITS_PER_BYTE + 1;
    localparam int CNT_W     = $clog2(ACK_CLK_I + 1);
    localparam logic [CNT_W-1:0] ACK_CLK  = CNT_W'(ACK_CLK_I);
    localparam logic [CNT_W-1:0] LAST_BIT = CNT_W'(BITS_PER_BYTE);

    trk_state_t       state_q, state_d;
    logic [CNT_W-1:0] cnt_q, cnt_d;
    logic             active;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= TRK_IDLE;
            cnt_q   <= '0;
        end else begin
            state_q <= state_d;
            cnt_q   <= cnt_d;
        end
    end

    assign active = (state_q != TRK_IDLE);

    always_comb begin
        state_d = state_q;
        cnt_d   = cnt_q;
        if (!enable || evt.stop) begin
            state_d = TRK_IDLE;
            cnt_d   = '0;
        end else if (evt.start) begin
            state_d = TRK_ADDR;
            cnt_d   = '0;
        end else if (evt.scl_rise) begin
            unique case (state_q)
                TRK_IDLE: begin
                    state_d = TRK_IDLE;
                    cnt_d   = '0;
                end
                TRK_ADDR: begin
                    if (cnt_q == ACK_CLK) begin
                        state_d = TRK_DATA;
                        cnt_d   = CNT_W'(1);
                    end else begin
                        cnt_d = cnt_q + CNT_W'(1);
                    end
                end
                TRK_DATA: begin
                    if (cnt_q == ACK_CLK) cnt_d = CNT_W'(1);
                    else                  cnt_d = cnt_q + CNT_W'(1);
                end
                default: begin
                    state_d = TRK_IDLE;
                    cnt_d   = '0;
                end
            endcase
        end
    end

    always_comb begin
        stb.addr_first = enable & evt.scl_rise & (state_q == TRK_ADDR) & (cnt_q == '0);
        stb.addr_done  = enable & evt.scl_rise & (state_q == TRK_ADDR) & (cnt_q == ACK_CLK);
        stb.byte_first = enable & evt.scl_rise & active & (cnt_q == ACK_CLK);
        stb.ack_low    = enable & evt.scl_rise & active & (cnt_q == LAST_BIT) & ~sda_level;
    end

    a_r3_count_in_range: assert property (@(posedge clk) disable iff (!rst_n)
        cnt_q <= ACK_CLK);
    a_r11_idle_count_zero: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == TRK_IDLE) |-> (cnt_q == '0));
    a_r9_start_restarts: assert property (@(posedge clk) disable iff (!rst_n)
        (enable && evt.start) |=> (state_q == TRK_ADDR && cnt_q == '0));
endmodule

// File: rtl/i2cmon_flags.sv
module i2cmon_flags
    import i2cmon_pkg::*;
(
    input  logic        clk,
    input  logic        rst_n,
    input  logic        enable,
    input  logic        release_pulse,
    input  bus_evt_t    evt,
    input  trk_strobe_t stb,
    output logic        start_flag,
    output logic        stop_flag,
    output logic        ack_flag,
    output logic        start_evt,
    output logic        stop_evt,
    output logic        ack_evt
);
    stp_state_t stp_q, stp_d;
    logic start_q, start_d;
    logic ack_q, ack_d;
    logic sevt_q, pevt_q, aevt_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            stp_q   <= STP_CLEAR;
            start_q <= 1'b0;
            ack_q   <= 1'b0;
            sevt_q  <= 1'b0;
            pevt_q  <= 1'b0;
            aevt_q  <= 1'b0;
        end else begin
            stp_q   <= stp_d;
            start_q <= start_d;
            ack_q   <= ack_d;
            sevt_q  <= enable & evt.start & ~release_pulse;
            pevt_q  <= enable & evt.stop;
            aevt_q  <= stb.ack_low & ~release_pulse;
        end
    end

    always_comb begin
        stp_d = stp_q;
        if (!enable) begin
            stp_d = STP_CLEAR;
        end else if (evt.stop) begin
            stp_d = STP_SET;
        end else begin
            unique case (stp_q)
                STP_CLEAR: stp_d = STP_CLEAR;
                STP_SET:   if (evt.start)      stp_d = STP_ARMED;
                STP_ARMED: if (stb.addr_first) stp_d = STP_CLEAR;
                default:   stp_d = STP_CLEAR;
            endcase
        end
    end

    always_comb begin
        start_d = start_q;
        if (!enable || release_pulse || evt.stop) start_d = 1'b0;
        else if (evt.start)                       start_d = 1'b1;
        else if (stb.addr_done)                   start_d = 1'b0;

        ack_d = ack_q;
        if (!enable || release_pulse || evt.stop || stb.byte_first) ack_d = 1'b0;
        else if (stb.ack_low)                                       ack_d = 1'b1;
    end

    assign start_flag = start_q;
    assign stop_flag  = (stp_q != STP_CLEAR);
    assign ack_flag   = ack_q;
    assign start_evt  = sevt_q;
    assign stop_evt   = pevt_q;
    assign ack_evt    = aevt_q;

    a_r7_release_keeps_stop: assert property (@(posedge clk) disable iff (!rst_n)
        (enable && release_pulse && stop_flag && !stb.addr_first) |=> stop_flag);
    a_r7_release_clears: assert property (@(posedge clk) disable iff (!rst_n)
        release_pulse |=> (!start_flag && !ack_flag));
    a_r1_evt_sets_start: assert property (@(posedge clk) disable iff (!rst_n)
        start_evt |-> start_flag);
    a_r2_stop_clears_others: assert property (@(posedge clk) disable iff (!rst_n)
        stop_evt |-> (stop_flag && !start_flag && !ack_flag));
    a_r3_evt_sets_ack: assert property (@(posedge clk) disable iff (!rst_n)
        ack_evt |-> ack_flag);
endmodule

// File: rtl/i2c_cond_monitor.sv
module i2c_cond_monitor
    import i2cmon_pkg::*;
#(
    parameter int SYNC_STAGES   = 2,
    parameter int BITS_PER_BYTE = 8
) (
    input  logic clk,
    input  logic rst_n,
    input  logic scl_in,
    input  logic sda_in,
    input  logic enable,
    input  logic release_pulse,
    output logic start_flag,
    output logic stop_flag,
    output logic ack_flag,
    output logic start_evt,
    output logic stop_evt,
    output logic ack_evt
);
    logic        scl_s, sda_s, sda_level;
    bus_evt_t    evt;
    trk_strobe_t stb;

    i2cmon_sync #(.STAGES(SYNC_STAGES)) u_sync_scl (
        .clk(clk), .rst_n(rst_n), .d(scl_in), .q(scl_s));
    i2cmon_sync #(.STAGES(SYNC_STAGES)) u_sync_sda (
        .clk(clk), .rst_n(rst_n), .d(sda_in), .q(sda_s));

    i2cmon_cond_detect u_detect (
        .clk(clk), .rst_n(rst_n), .scl_s(scl_s), .sda_s(sda_s),
        .evt(evt), .sda_level(sda_level));

    i2cmon_bit_track #(.BITS_PER_BYTE(BITS_PER_BYTE)) u_track (
        .clk(clk), .rst_n(rst_n), .enable(enable), .evt(evt),
        .sda_level(sda_level), .stb(stb));

    i2cmon_flags u_flags (
        .clk(clk), .rst_n(rst_n), .enable(enable), .release_pulse(release_pulse),
        .evt(evt), .stb(stb),
        .start_flag(start_flag), .stop_flag(stop_flag), .ack_flag(ack_flag),
        .start_evt(start_evt), .stop_evt(stop_evt), .ack_evt(ack_evt));

    a_r8_quiet_when_disabled: assert property (@(posedge clk) disable iff (!rst_n)
        !enable |=> (!start_flag && !stop_flag && !ack_flag &&
                     !start_evt && !stop_evt && !ack_evt));
    a_r12_start_stop_apart: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0({start_evt, stop_evt}));
endmodule

// File: tb/i2c_cond_monitor_bench.sv
module i2c_cond_monitor_bench;
    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic scl = 1'b1;
    logic sda = 1'b1;
    logic enable = 1'b0;
    logic rel = 1'b0;
    logic start_flag, stop_flag, ack_flag, start_evt, stop_evt, ack_evt;

    int checks = 0;
    int errors = 0;
    int n_start = 0, n_stop = 0, n_ack = 0;
    int cycles = 0;
    bit done = 1'b0;

    always #2 clk = ~clk;

    i2c_cond_monitor u_i2c_cond_monitor (
        .clk(clk), .rst_n(rst_n), .scl_in(scl), .sda_in(sda),
        .enable(enable), .release_pulse(rel),
        .start_flag(start_flag), .stop_flag(stop_flag), .ack_flag(ack_flag),
        .start_evt(start_evt), .stop_evt(stop_evt), .ack_evt(ack_evt));

    always @(negedge clk) begin
        if (start_evt) n_start++;
        if (stop_evt)  n_stop++;
        if (ack_evt)   n_ack++;
    end

    always @(posedge clk) begin
        cycles++;
        if (cycles > 150000 && !done) begin
            done = 1'b1;
            checks++;
            errors++;
            $display("FAIL watchdog: act=%0d cycles exp<150000", cycles);
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end

    task automatic chk_flags(input string req, input logic [2:0] exp);
        logic [2:0] act;
        act = {start_flag, stop_flag, ack_flag};
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s flags{start,stop,ack}: act=%b exp=%b", req, act, exp);
        end
    endtask

    task automatic chk_int(input string req, input int act, input int exp);
        checks++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s: act=%0d exp=%0d", req, act, exp);
        end
    endtask

    task automatic settle();
        repeat (8) @(posedge clk);
        #1;
    endtask

    task automatic drive(input logic s, input logic d);
        scl = s;
        sda = d;
        settle();
    endtask

    task automatic bus_start();
        if (!scl) drive(1'b0, 1'b1);
        drive(1'b1, 1'b1);
        drive(1'b1, 1'b0);
        drive(1'b0, 1'b0);
    endtask

    task automatic bus_bit(input logic b);
        drive(1'b0, b);
        drive(1'b1, b);
        drive(1'b0, b);
    endtask

    task automatic bus_stop();
        drive(1'b0, 1'b0);
        drive(1'b1, 1'b0);
        drive(1'b1, 1'b1);
    endtask

    task automatic pulse_release();
        rel = 1'b1;
        @(posedge clk);
        #1;
        rel = 1'b0;
        settle();
    endtask

    initial begin
        int s0, p0, a0, exp_acks;
        logic prev_stop;
        logic [7:0] val;
        settle();
        chk_flags("R10 reset", 3'b000);
        chk_int("R10 no pulses in reset", n_start + n_stop + n_ack, 0);
        rst_n = 1'b1;
        enable = 1'b1;
        settle();
        chk_flags("R10 after reset", 3'b000);

        // R11: clocks before any start change nothing
        for (int i = 0; i < 10; i++) bus_bit(1'b0);
        chk_flags("R11 clocks before start", 3'b000);
        chk_int("R11 no ack pulse", n_ack, 0);
        drive(1'b1, 1'b1);

        prev_stop = 1'b0;
        for (int nb = 0; nb < 4; nb++) begin
            for (int ackv = 0; ackv < 2; ackv++) begin
                for (int pat = 0; pat < 3; pat++) begin
                    s0 = n_start; p0 = n_stop; a0 = n_ack; exp_acks = 0;
                    bus_start();
                    chk_flags("R1/R6 after start", {1'b1, prev_stop, 1'b0});
                    val = 8'h5A ^ 8'(pat * 37 + nb);
                    for (int b = 7; b >= 0; b--) begin
                        bus_bit(val[b]);
                        if (b == 7) chk_flags("R6 stop cleared on first address clock", 3'b100);
                    end
                    chk_flags("R5 start held through address", 3'b100);
                    bus_bit(ackv[0]);
                    if (ackv == 0) exp_acks++;
                    chk_flags("R3 address ack", {1'b1, 1'b0, ~ackv[0]});
                    for (int k = 0; k < nb; k++) begin
                        val = 8'hC3 + 8'(k * 29 + pat);
                        for (int b = 7; b >= 0; b--) begin
                            bus_bit(val[b]);
                            if (b == 7) chk_flags("R4/R5 first clock of next byte", 3'b000);
                        end
                        bus_bit(ackv[0] ^ k[0]);
                        if ((ackv[0] ^ k[0]) == 1'b0) exp_acks++;
                        chk_flags("R3 data ack", {2'b00, ~(ackv[0] ^ k[0])});
                    end
                    if (pat != 1) begin
                        bus_stop();
                        chk_flags("R2 after stop", 3'b010);
                        prev_stop = 1'b1;
                    end else begin
                        drive(1'b0, 1'b1);
                        prev_stop = 1'b0;
                    end
                    chk_int("R12 start pulses", n_start - s0, 1);
                    chk_int("R12 stop pulses", n_stop - p0, (pat != 1) ? 1 : 0);
                    chk_int("R3 ack pulses", n_ack - a0, exp_acks);
                end
            end
        end

        // R7: release clears start and ack, keeps stop
        if (!scl) bus_stop();
        chk_flags("R2 bus released", 3'b010);
        bus_start();
        pulse_release();
        chk_flags("R7 release after start keeps stop", 3'b010);
        bus_start();
        for (int b = 0; b < 8; b++) bus_bit(1'b1);
        bus_bit(1'b0);
        chk_flags("R3 ack before release", 3'b101);
        pulse_release();
        chk_flags("R7 release clears start and ack", 3'b000);
        bus_stop();
        pulse_release();
        chk_flags("R7 release leaves stop set", 3'b010);

        // R9: repeated start in mid data byte
        bus_start();
        for (int b = 0; b < 9; b++) bus_bit(1'b0);
        bus_bit(1'b1);
        bus_bit(1'b1);
        chk_flags("R5 in data byte", 3'b000);
        s0 = n_start;
        bus_start();
        chk_flags("R9 repeated start", 3'b100);
        for (int b = 0; b < 8; b++) bus_bit(1'b1);
        bus_bit(1'b0);
        chk_flags("R9 start held nine clocks after repeat", 3'b101);
        bus_bit(1'b1);
        chk_flags("R9 start cleared on tenth clock", 3'b000);
        chk_int("R12 repeated start pulse", n_start - s0, 1);

        // R8: enable low
        bus_stop();
        bus_start();
        chk_flags("R8 flags set before disable", 3'b110);
        enable = 1'b0;
        settle();
        chk_flags("R8 disabled clears", 3'b000);
        s0 = n_start; p0 = n_stop; a0 = n_ack;
        for (int b = 0; b < 9; b++) bus_bit(1'b0);
        bus_stop();
        bus_start();
        chk_flags("R8 disabled ignores bus", 3'b000);
        chk_int("R8 no pulses while disabled", (n_start - s0) + (n_stop - p0) + (n_ack - a0), 0);
        enable = 1'b1;
        settle();
        chk_flags("R8 re-enabled stays clear", 3'b000);
        for (int b = 0; b < 9; b++) bus_bit(1'b0);
        chk_flags("R8/R11 no start seen after re-enable", 3'b000);
        bus_stop();
        chk_flags("R2 stop after re-enable", 3'b010);

        done = 1'b1;
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end
endmodule